// File: doc/BRIEF.md
# Fetch Address Sequence Guard

This block watches the fetch address that the front end of a pipelined processor presents with each instruction. It is a countermeasure against fault injection. Each time a new instruction is accepted, the block predicts the next sequential address. The prediction is the accepted address plus 2 if that instruction is a 16-bit compressed encoding, or plus 4 otherwise. The next accepted address must match the prediction. A wrong address means the flow was disturbed, and the block raises an unrecoverable alert.

The comparison runs only on straight-line flow. A redirect (a branch, a jump or an exception) disarms it. Reset also disarms it. The first address accepted after either event becomes the new base and is not compared. Stall cycles, where no instruction is accepted, leave the prediction unchanged. The alert is a registered level. It rises one clock edge after the offending fetch and holds until reset.

Top module: `fetch_pc_guard`

## Requirements
- R1: While reset is high and on the first edge after it, the alert output is 0. The first accepted fetch after reset is never compared, whatever its address.
- R2: When the previous accepted instruction was not compressed (compressed flag 0), an accepted fetch at previous address + 4 causes no alert.
- R3: When the previous accepted instruction was compressed (compressed flag 1), an accepted fetch at previous address + 2 causes no alert.
- R4: An armed, accepted fetch without redirect whose address differs from the prediction sets the alert at the next rising clock edge.
- R5: Once set, the alert stays at 1 until synchronous reset, whatever the later inputs are.
- R6: A cycle with the valid input low neither compares nor changes the prediction. Its address and compressed inputs are ignored.
- R7: A fetch accepted with the redirect input high is not compared. Its address becomes the new base.
- R8: A redirect pulse with the valid input low disarms the comparison. The next accepted fetch is not compared and becomes the new base.
- R9: Address arithmetic wraps modulo 2^AW without any alert. For example, 0xFFFFFFFC followed by 0x00000000 is legal.
- R10: An increment that is wrong for the instruction's size raises the alert. Examples are +4 after a compressed instruction and +2 after a full-size one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_valid_i | input | 1 | An instruction at pc_i is accepted this cycle |
| pc_i | input | AW | Fetch address of the accepted instruction |
| compressed_i | input | 1 | 1 if the accepted instruction is 16-bit compressed |
| redirect_i | input | 1 | Control flow was redirected; pc_i (if valid) is a target |
| alert_o | output | 1 | Sticky registered mismatch alert |

## Verification
The assertions assume that a redirect is reported either in the same cycle as its target fetch or before it. They also assume that every input is driven to a known level once reset has been released. The stimulus changes the inputs only on the falling clock edge and always drives known values. It pairs every redirect with its target fetch or places the redirect ahead of it. It places stalls that carry garbage addresses between fetches, so that the ignored inputs really do differ from the expected ones.

// File: rtl/fpg_pkg.sv
package fpg_pkg;
  localparam int unsigned FPG_AW_DEFAULT = 32;
  localparam int unsigned FPG_HALF_BYTES = 2;
  localparam int unsigned FPG_FULL_BYTES = 4;
endpackage

// File: rtl/fpg_base_reg.sv
module fpg_base_reg #(
  parameter int unsigned AW = fpg_pkg::FPG_AW_DEFAULT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          valid_i,
  input  logic          redirect_i,
  input  logic [AW-1:0] pc_i,
  input  logic          comp_i,
  output logic [AW-1:0] base_pc_o,
  output logic          base_comp_o,
  output logic          armed_o
);
  // Base captured only on accepted fetches; redirect without fetch disarms.
  always_ff @(posedge clk) begin
    if (rst) begin
      base_pc_o   <= '0;
      base_comp_o <= 1'b0;
      armed_o     <= 1'b0;
    end else if (valid_i) begin
      base_pc_o   <= pc_i;
      base_comp_o <= comp_i;
      armed_o     <= 1'b1;
    end else if (redirect_i) begin
      armed_o     <= 1'b0;
    end
  end
endmodule

// File: rtl/fpg_step_cmp.sv
module fpg_step_cmp #(
  parameter int unsigned AW         = fpg_pkg::FPG_AW_DEFAULT,
  parameter int unsigned HALF_BYTES = fpg_pkg::FPG_HALF_BYTES,
  parameter int unsigned FULL_BYTES = fpg_pkg::FPG_FULL_BYTES
) (
  input  logic          valid_i,
  input  logic          redirect_i,
  input  logic          armed_i,
  input  logic [AW-1:0] base_pc_i,
  input  logic          base_comp_i,
  input  logic [AW-1:0] pc_i,
  output logic          mismatch_o
);
  localparam logic [AW-1:0] STEP_HALF = AW'(HALF_BYTES);
  localparam logic [AW-1:0] STEP_FULL = AW'(FULL_BYTES);

  logic [AW-1:0] predicted;
  logic          check_en;

  always_comb begin
    predicted  = base_pc_i + (base_comp_i ? STEP_HALF : STEP_FULL);
    check_en   = valid_i & armed_i & ~redirect_i;
    mismatch_o = check_en & (pc_i != predicted);
  end
endmodule

// File: rtl/fpg_alert_hold.sv
module fpg_alert_hold (
  input  logic clk,
  input  logic rst,
  input  logic mismatch_i,
  output logic alert_o
);
  always_ff @(posedge clk) begin
    if (rst) alert_o <= 1'b0;
    else     alert_o <= alert_o | mismatch_i;
  end
endmodule

// File: rtl/fetch_pc_guard.sv
module fetch_pc_guard #(
  parameter int unsigned AW         = fpg_pkg::FPG_AW_DEFAULT,
  parameter int unsigned HALF_BYTES = fpg_pkg::FPG_HALF_BYTES,
  parameter int unsigned FULL_BYTES = fpg_pkg::FPG_FULL_BYTES
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pc_valid_i,
  input  logic [AW-1:0] pc_i,
  input  logic          compressed_i,
  input  logic          redirect_i,
  output logic          alert_o
);
  logic [AW-1:0] base_pc;
  logic          base_comp;
  logic          armed;
  logic          mismatch;

  fpg_base_reg #(.AW(AW)) u_base (
    .clk         (clk),
    .rst         (rst),
    .valid_i     (pc_valid_i),
    .redirect_i  (redirect_i),
    .pc_i        (pc_i),
    .comp_i      (compressed_i),
    .base_pc_o   (base_pc),
    .base_comp_o (base_comp),
    .armed_o     (armed)
  );

  fpg_step_cmp #(.AW(AW), .HALF_BYTES(HALF_BYTES), .FULL_BYTES(FULL_BYTES)) u_cmp (
    .valid_i     (pc_valid_i),
    .redirect_i  (redirect_i),
    .armed_i     (armed),
    .base_pc_i   (base_pc),
    .base_comp_i (base_comp),
    .pc_i        (pc_i),
    .mismatch_o  (mismatch)
  );

  fpg_alert_hold u_alert (
    .clk        (clk),
    .rst        (rst),
    .mismatch_i (mismatch),
    .alert_o    (alert_o)
  );
endmodule

// File: rtl/fpg_checker.sv
module fpg_checker #(
  parameter int unsigned AW = fpg_pkg::FPG_AW_DEFAULT
) (
  input logic          clk,
  input logic          rst,
  input logic          pc_valid_i,
  input logic [AW-1:0] pc_i,
  input logic          compressed_i,
  input logic          redirect_i,
  input logic          alert_o
);
  logic rst_seen;
  always_ff @(posedge clk) rst_seen <= rst;

  // R1: alert low on the edge after a reset cycle
  always_ff @(posedge clk) begin
    if (rst_seen === 1'b1) a_r1_quiet_after_reset: assert (alert_o == 1'b0);
  end

  // R5
  a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
    alert_o |=> alert_o);

  // R6
  a_r6_stall_silent: assert property (@(posedge clk) disable iff (rst)
    (!pc_valid_i && !alert_o) |=> !alert_o);

  // R7
  a_r7_redirect_silent: assert property (@(posedge clk) disable iff (rst)
    (redirect_i && !alert_o) |=> !alert_o);

  // R4: a rise is caused only by an accepted, non-redirected fetch
  a_r4_rise_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(alert_o) |-> ($past(pc_valid_i) && !$past(redirect_i)));

  logic unused_ok;
  assign unused_ok = ^{pc_i, compressed_i};
endmodule

bind fetch_pc_guard fpg_checker #(.AW(AW)) u_fpg_checker (
  .clk          (clk),
  .rst          (rst),
  .pc_valid_i   (pc_valid_i),
  .pc_i         (pc_i),
  .compressed_i (compressed_i),
  .redirect_i   (redirect_i),
  .alert_o      (alert_o)
);

// File: tb/fetch_pc_guard_tb_top.sv
module fetch_pc_guard_tb_top;
  localparam int unsigned AW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pc_valid_i = 1'b0;
  logic [AW-1:0] pc_i = '0;
  logic          compressed_i = 1'b0;
  logic          redirect_i = 1'b0;
  logic          alert_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic          m_armed, m_comp, m_alert;
  logic [AW-1:0] m_prev;

  always #5 clk = ~clk;

  fetch_pc_guard #(.AW(AW)) dut_i (
    .clk(clk), .rst(rst), .pc_valid_i(pc_valid_i), .pc_i(pc_i),
    .compressed_i(compressed_i), .redirect_i(redirect_i), .alert_o(alert_o)
  );

  task automatic check(input string req, input logic exp);
    checks++;
    if (alert_o !== exp) begin
      errors++;
      $display("FAIL %s: alert_o=%b expected %b", req, alert_o, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; pc_valid_i = 1'b0; redirect_i = 1'b0;
    @(posedge clk); #1;
    m_armed = 1'b0; m_comp = 1'b0; m_alert = 1'b0; m_prev = '0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Drive one cycle, update the model, check the alert after the edge.
  task automatic step(input string req, input logic v, input logic [AW-1:0] pc,
                      input logic c, input logic r);
    logic [AW-1:0] inc;
    @(negedge clk);
    pc_valid_i = v; pc_i = pc; compressed_i = c; redirect_i = r;
    inc = m_comp ? AW'(2) : AW'(4);
    if (v && m_armed && !r && (pc != m_prev + inc)) m_alert = 1'b1;
    if (v) begin m_prev = pc; m_comp = c; m_armed = 1'b1; end
    else if (r) m_armed = 1'b0;
    @(posedge clk); #1;
    check(req, m_alert);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state and unchecked first fetch
    @(posedge clk); #1;
    check("R1", 1'b0);
    do_reset();
    check("R1", 1'b0);
    step("R1", 1'b1, 32'h1234_5677, 1'b0, 1'b0);

    // R2/R3/R4/R10: sweep of offsets after both instruction sizes
    for (int c = 0; c < 2; c++) begin
      for (int d = -6; d <= 10; d++) begin
        do_reset();
        step("R1", 1'b1, AW'(32'h400 + (d + 6) * 64), c[0], 1'b0);
        step((d == (c ? 2 : 4)) ? (c ? "R3" : "R2") : ((d == 2 || d == 4) ? "R10" : "R4"),
             1'b1, AW'(32'h400 + (d + 6) * 64 + d), 1'b0, 1'b0);
      end
    end

    // R2/R3: longer mixed legal run
    do_reset();
    step("R2", 1'b1, 32'h1000, 1'b1, 1'b0);
    step("R3", 1'b1, 32'h1002, 1'b0, 1'b0);
    step("R2", 1'b1, 32'h1006, 1'b1, 1'b0);
    step("R3", 1'b1, 32'h1008, 1'b1, 1'b0);
    step("R3", 1'b1, 32'h100A, 1'b0, 1'b0);

    // R6: stalls carrying garbage are ignored
    step("R6", 1'b0, 32'hDEAD_BEEF, 1'b1, 1'b0);
    step("R6", 1'b0, 32'h0000_0000, 1'b0, 1'b0);
    step("R6", 1'b1, 32'h100E, 1'b0, 1'b0);

    // R7: redirect with target fetch
    step("R7", 1'b1, 32'h8000_0000, 1'b1, 1'b1);
    step("R7", 1'b1, 32'h8000_0002, 1'b0, 1'b0);

    // R8: redirect pulse without fetch, then target
    step("R8", 1'b0, 32'h0, 1'b0, 1'b1);
    step("R8", 1'b0, 32'h5555_5555, 1'b0, 1'b0);
    step("R8", 1'b1, 32'h0000_3000, 1'b0, 1'b0);
    step("R8", 1'b1, 32'h0000_3004, 1'b0, 1'b0);

    // R9: wrap-around with both sizes
    do_reset();
    step("R9", 1'b1, 32'hFFFF_FFFC, 1'b0, 1'b0);
    step("R9", 1'b1, 32'h0000_0000, 1'b0, 1'b0);
    do_reset();
    step("R9", 1'b1, 32'hFFFF_FFFE, 1'b1, 1'b0);
    step("R9", 1'b1, 32'h0000_0000, 1'b0, 1'b0);

    // R5: sticky after a fault, cleared only by reset
    step("R4", 1'b1, 32'h0000_0010, 1'b0, 1'b0);
    step("R5", 1'b1, 32'h0000_0014, 1'b0, 1'b0);
    step("R5", 1'b0, 32'h0, 1'b0, 1'b1);
    step("R5", 1'b1, 32'h0000_0100, 1'b0, 1'b1);
    do_reset();
    check("R5", 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule